// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes one active-low interrupt pin from outside the chip and turns it into an interrupt request for the processor. The pin goes through a chain of synchronizing flip-flops. A falling edge of the synchronized level sets a pending latch. A mode bit picks one of two trigger types. In edge mode the latch holds until it is acknowledged. In edge-and-level mode the request also stays pending for as long as the pin is held low.

The pending latch is cleared in three ways: by a vector-fetch pulse from the processor, by software writing a one to the acknowledge bit, or by reset. A mask bit stops a pending request from reaching the request output, but the latch keeps its state while masked. A small status and control register gives software access to the mode bit, the mask bit, the flag and the acknowledge bit. The synchronized pin level is also driven out on its own port, so that branch-on-pin-level instructions can test it.

Top module: `extirq_ctrl`

## Requirements
- R1: While reset is asserted, reg_rdata reads 0x00 and irq_req is 0, even if the pin is held low. Reset also clears the mode and mask bits.
- R2: A falling edge of pin_n sets the flag after exactly SYNC_STAGES+1 rising clock edges, in both modes. pin_level follows pin_n after SYNC_STAGES edges.
- R3: In edge mode (mode bit 0), the flag stays set while the pin stays low. It stays set until an acknowledge arrives, and it clears on the edge that takes the acknowledge.
- R4: A vec_fetch pulse clears the flag in the same way as a software acknowledge.
- R5: Writing 0 to the acknowledge bit (bit 2) has no effect on the flag. Bit 2 always reads 0.
- R6: In level mode (mode bit 1), an acknowledge given while the pin is low does not clear the flag. The flag then clears SYNC_STAGES+1 edges after the pin rises.
- R7: In level mode, if the pin is already high when the acknowledge arrives, the flag clears on that edge.
- R8: irq_req is the flag gated by the mask bit (bit 1). While masked, the flag still reads back as 1, and the request appears once the mask is cleared.
- R9: If a falling edge is detected in the same cycle as an acknowledge, the edge wins and the flag is set.
- R10: Register layout: bit 3 is the flag (read-only), bit 2 is the acknowledge bit (write-only), bit 1 is the mask bit and bit 0 is the mode bit. Bits 1 and 0 read back what was written, and all higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Raw active-low interrupt pin |
| vec_fetch | input | 1 | One-cycle pulse when the processor fetches this interrupt's vector |
| reg_wr | input | 1 | Write strobe for the status/control register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the status/control register |
| irq_req | output | 1 | Interrupt request after masking |
| pin_level | output | 1 | Synchronized pin level |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default of 2. This checks that every latency follows the parameter and is not fixed at the default: flag set, pin_level tracking, and the level-mode clear after the pin rises. REG_W stays at 8, so the bench can check that the upper read bits are zero. A random phase with slowly changing pin levels, random acknowledges and random mode and mask writes reaches cases that directed tests rarely hit. These include an acknowledge coinciding with an edge, mode changes while a request is pending, and ordering races in level mode.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
   localparam int unsigned BIT_MODE = 0;
   localparam int unsigned BIT_MASK = 1;
   localparam int unsigned BIT_ACK  = 2;
   localparam int unsigned BIT_FLAG = 3;
   localparam int unsigned CTRL_BITS = 4;

   typedef enum logic {
      TRIG_EDGE       = 1'b0,
      TRIG_EDGE_LEVEL = 1'b1
   } trig_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        IDLE_LVL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic level,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= IDLE_LVL;
               else        chain_q[0] <= pin_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= IDLE_LVL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   assign fall  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/extirq_latch.sv
module extirq_latch
   import extirq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  trig_e trig,
   input  logic  fall,
   input  logic  pin_hi,
   input  logic  ack,
   output logic  pend
);
   logic pend_q, acked_q;
   logic pend_d, acked_d;

   always_comb begin
      pend_d  = pend_q;
      acked_d = acked_q;
      if (fall) begin
         pend_d  = 1'b1;
         acked_d = 1'b0;
      end else if (trig == TRIG_EDGE) begin
         acked_d = 1'b0;
         if (ack) pend_d = 1'b0;
      end else if (pend_q) begin
         if ((ack || acked_q) && pin_hi) begin
            pend_d  = 1'b0;
            acked_d = 1'b0;
         end else if (ack) begin
            acked_d = 1'b1;
         end
      end else begin
         acked_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         acked_q <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         acked_q <= acked_d;
      end
   end

   assign pend = pend_q;
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
   import extirq_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             flag,
   output logic [REG_W-1:0] rdata,
   output trig_e            trig,
   output logic             mask,
   output logic             sw_ack
);
   logic mode_q, mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         mask_q <= 1'b0;
      end else if (wr) begin
         mode_q <= wdata[BIT_MODE];
         mask_q <= wdata[BIT_MASK];
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[BIT_MODE] = mode_q;
      rdata[BIT_MASK] = mask_q;
      rdata[BIT_FLAG] = flag;
   end

   assign trig   = trig_e'(mode_q);
   assign mask   = mask_q;
   assign sw_ack = wr & wdata[BIT_ACK];
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
   import extirq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_W       = 8,
   parameter logic        PIN_IDLE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_n,
   input  logic             vec_fetch,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq_req,
   output logic             pin_level
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("extirq_ctrl: SYNC_STAGES must be at least 2");
      end
      if (REG_W < CTRL_BITS) begin : g_bad_width
         $error("extirq_ctrl: REG_W too narrow for control bits");
      end
   endgenerate

   logic  fall, sw_ack, mask, pend;
   trig_e trig;

   extirq_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .level(pin_level), .fall(fall)
   );

   extirq_regs #(.REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .flag(pend),
      .rdata(reg_rdata), .trig(trig), .mask(mask), .sw_ack(sw_ack)
   );

   extirq_latch u_latch (
      .clk(clk), .rst_n(rst_n), .trig(trig), .fall(fall), .pin_hi(pin_level),
      .ack(sw_ack | vec_fetch), .pend(pend)
   );

   assign irq_req = pend & ~mask;
endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vec_fetch,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             irq_req,
   input logic             pin_level
);
   logic flag, mode, mask, any_ack;
   assign flag    = reg_rdata[3];
   assign mode    = reg_rdata[0];
   assign mask    = reg_rdata[1];
   assign any_ack = vec_fetch | (reg_wr & reg_wdata[2]);

   a_r2_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_level) |=> flag);

   a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && flag && !any_ack) |=> flag);

   a_r4_fetch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && vec_fetch && pin_level) |=> !flag);

   a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && flag && !pin_level) |=> flag);

   a_r8_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (flag && !mask));
endmodule

bind extirq_ctrl extirq_ctrl_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vec_fetch(vec_fetch), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
   .pin_level(pin_level)
);

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
   localparam int unsigned S = 3;
   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         pin_n;
   logic         vec_fetch;
   logic         reg_wr;
   logic [W-1:0] reg_wdata;
   logic [W-1:0] reg_rdata;
   logic         irq_req;
   logic         pin_level;

   int n_chk = 0;
   int n_bad = 0;

   // model state
   logic [S-1:0] m_hist;
   logic m_prev, m_pend, m_acked, m_mode, m_mask;

   always #2.5 clk = ~clk;

   extirq_ctrl #(.SYNC_STAGES(S), .REG_W(W)) u_extirq_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .vec_fetch(vec_fetch),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .pin_level(pin_level)
   );

   function automatic logic [W-1:0] exp_rdata();
      logic [W-1:0] r = '0;
      r[3] = m_pend; r[1] = m_mask; r[0] = m_mode;
      return r;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_hist = '1; m_prev = 1'b1; m_pend = 0; m_acked = 0; m_mode = 0; m_mask = 0;
   endtask

   task automatic model_edge(input logic p, input logic vf, input logic we, input logic [W-1:0] wd);
      logic fall, ack, hi;
      fall = m_prev & ~m_hist[S-1];
      hi   = m_hist[S-1];
      ack  = vf | (we & wd[2]);
      if (fall) begin
         m_pend = 1; m_acked = 0;
      end else if (!m_mode) begin
         m_acked = 0;
         if (ack) m_pend = 0;
      end else if (m_pend) begin
         if ((ack || m_acked) && hi) begin m_pend = 0; m_acked = 0; end
         else if (ack) m_acked = 1;
      end else m_acked = 0;
      m_prev = m_hist[S-1];
      m_hist = {m_hist[S-2:0], p};
      if (we) begin m_mode = wd[0]; m_mask = wd[1]; end
   endtask

   // one clock: drive at negedge, edge, sample at next negedge
   task automatic step(input logic p, input logic vf, input logic we, input logic [W-1:0] wd);
      pin_n = p; vec_fetch = vf; reg_wr = we; reg_wdata = wd;
      @(posedge clk);
      model_edge(p, vf, we, wd);
      @(negedge clk);
      vec_fetch = 0; reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(pin_n, 0, 0, '0);
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; pin_n = 0; vec_fetch = 0; reg_wr = 0; reg_wdata = '0;
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 rdata in reset", reg_rdata, 8'h00);
      check("R1 irq in reset", {7'd0, irq_req}, 8'h00);
      pin_n = 1;
      repeat (S + 2) @(negedge clk);
      rst_n = 1;
      idle(4);

      // R10 register layout
      step(1, 0, 1, 8'hF3);
      check("R10 mode/mask readback", reg_rdata, 8'h03);
      step(1, 0, 1, 8'h00);
      check("R10 cleared", reg_rdata, 8'h00);

      // R2 edge latency, R3 edge hold
      for (int i = 1; i <= S + 1; i++) begin
         step(0, 0, 0, '0);
         if (i == S) begin
            check("R2 pin_level after S edges", {7'd0, pin_level}, 8'h00);
            check("R2 flag not yet", reg_rdata, 8'h00);
         end
      end
      check("R2 flag set", reg_rdata, 8'h08);
      check("R2 irq set", {7'd0, irq_req}, 8'h01);
      idle(5);
      check("R3 edge hold while low", reg_rdata, 8'h08);
      step(0, 0, 1, 8'h00);
      check("R5 ack=0 no effect", reg_rdata, 8'h08);
      step(0, 0, 1, 8'h04);
      check("R3 sw ack clears", reg_rdata, 8'h00);
      idle(3);
      check("R3 stays clear while low", reg_rdata, 8'h00);
      step(1, 0, 0, '0); idle(S + 2);

      // R4 vector fetch
      step(0, 0, 0, '0); idle(S + 2);
      step(0, 1, 0, '0);
      check("R4 vec_fetch clears", reg_rdata, 8'h00);
      step(1, 0, 0, '0); idle(S + 2);

      // R8 mask
      step(1, 0, 1, 8'h02);
      step(0, 0, 0, '0); idle(S + 2);
      check("R8 masked flag reads", reg_rdata, 8'h0A);
      check("R8 masked irq low", {7'd0, irq_req}, 8'h00);
      step(0, 0, 1, 8'h00);
      check("R8 unmask shows irq", {7'd0, irq_req}, 8'h01);
      step(0, 0, 1, 8'h04);
      step(1, 0, 0, '0); idle(S + 2);

      // R6 level mode: ack while low, then rise
      step(1, 0, 1, 8'h01);
      step(0, 0, 0, '0); idle(S + 2);
      step(0, 0, 1, 8'h05);
      idle(4);
      check("R6 ack while low holds", reg_rdata, 8'h09);
      for (int i = 1; i <= S + 1; i++) begin
         step(1, 0, 0, '0);
         if (i == S) check("R6 still set before sync", reg_rdata, 8'h09);
      end
      check("R6 clears after rise", reg_rdata, 8'h01);

      // R7 level mode: pin high first, then ack
      step(0, 0, 0, '0); idle(S + 2);
      step(1, 0, 0, '0); idle(S + 3);
      check("R7 no ack keeps set", reg_rdata, 8'h09);
      step(1, 1, 0, '0);
      check("R7 ack with pin high clears", reg_rdata, 8'h01);

      // R9 edge beats ack in same cycle
      step(1, 0, 1, 8'h00);
      for (int i = 1; i <= S; i++) step(0, 0, 0, '0);
      step(0, 1, 0, '0);
      check("R9 edge wins over ack", reg_rdata, 8'h08);
      step(0, 0, 1, 8'h04);
      step(1, 0, 0, '0); idle(S + 2);

      // random phase against model
      begin
         int seed_dummy;
         logic p;
         seed_dummy = $urandom(32'h1E5C);
         p = 1;
         for (int i = 0; i < 3000; i++) begin
            logic vf, we;
            logic [W-1:0] wd;
            if ($urandom_range(0, 5) == 0) p = ~p;
            vf = ($urandom_range(0, 15) == 0);
            we = ($urandom_range(0, 7) == 0);
            wd = W'($urandom_range(0, 255));
            step(p, vf, we, wd);
            check("R3/R6/R8 random rdata", reg_rdata, exp_rdata());
            check("R8 random irq", {7'd0, irq_req}, {7'd0, m_pend & ~m_mask});
            check("R2 random pin_level", {7'd0, pin_level}, {7'd0, m_hist[S-1]});
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule